// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a virtual page to a physical address by searching a hashed page table held in memory. A request carries a segment identifier, a page index, an abbreviated page index, a 12-bit byte offset and an access kind. The walker forms a group address from a hash of the segment identifier and page index. It reads the first word of each entry in that group until one matches. If the whole group misses, it searches a second group reached through the complemented hash.

On a hit, the walker fetches the entry's second word and updates its referenced and changed flags as the access kind requires. It writes that word back to memory, except when the access is a probe. It then reports the physical address, and for non-probe accesses it presents the updated entry on a fill port for a translation cache. When both groups miss, it reports a fault. Memory is reached over a single-outstanding 32-bit request/response port. Words are taken as big-endian, so the most significant byte of each word is at the lowest address. A flag marks accesses that fall in a second memory region.

Top module: `pgw_walker`

## Requirements
- R1: A request on `req_valid` is accepted only while `busy` is low. `busy` stays high from the cycle after acceptance until the cycle after `done`. Request inputs that change while busy have no effect on the walk.
- R2: The primary hash is the low 19 bits of the segment ID XORed with the zero-extended page index. The group address is ((hash AND `cfg_hmask`) shifted left by 6) ORed with `cfg_base`.
- R3: Within a group, the walker reads word 0 of entries 0 to 7 in order, at group address + 8*slot. It reads word 1 at entry address + 4 only for the matching entry.
- R4: Word 0 holds valid in bit 31, the segment ID in bits 30:7, the hash-select bit in bit 6 and the abbreviated page index in bits 5:0. An entry matches when it is valid, both ID fields equal the request, and hash-select is 0 on the primary pass or 1 on the secondary pass.
- R5: After eight misses in the primary group, the walker searches the group formed from the bitwise complement of the 19-bit primary hash.
- R6: Access kind is encoded probe=0, read=1, write=2, fetch=3. In word 1, the referenced flag (bit 8) is set for read, write and fetch. The changed flag (bit 7) is set only for write. Probe leaves the word unchanged.
- R7: For every kind except probe, the updated word 1 is written back to entry address + 4. A probe performs no write.
- R8: `done` is a one-cycle pulse. On a hit, `paddr` equals word 1 bits 31:12 shifted left by 12, ORed with the request offset.
- R9: If neither group holds a match, `done` is raised with `fault` high, after exactly 16 word reads.
- R10: On a non-probe hit, `fill_valid` pulses with `done`. `fill_pte` then carries the updated word 1, and `fill_tag` carries {segment ID, page index}. `fill_valid` stays low on probes and faults.
- R11: `mem_alt` is high on an access exactly when bits 31:28 of the group address equal 4'h1.
- R12: At most one memory request is outstanding. `mem_req` lasts one cycle, and the walker waits for `mem_rvalid` after every read and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a translation |
| req_sid | input | 24 | Segment identifier |
| req_pix | input | 16 | Page index |
| req_api | input | 6 | Abbreviated page index |
| req_offset | input | 12 | Byte offset within the page |
| req_kind | input | 2 | Access kind (probe, read, write, fetch) |
| cfg_base | input | 32 | Page table base address |
| cfg_hmask | input | 19 | Hash mask |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_alt | output | 1 | Second memory region select |
| mem_rvalid | input | 1 | Response or write acknowledge |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Walk finished |
| fault | output | 1 | No matching entry |
| paddr | output | 32 | Physical address |
| fill_valid | output | 1 | Entry offered to translation cache |
| fill_tag | output | 40 | Segment ID and page index of the fill |
| fill_pte | output | 32 | Updated second entry word |

## Verification
The bench places decoy entries next to real ones:
- A matching entry whose hash-select bit names the wrong pass. A design that ignores that bit would stop on it in the primary group instead of going on to the secondary one.
- Invalid entries and entries whose abbreviated index differs by one. A loose compare would return the wrong page number.
- A hit in the last slot. An off-by-one slot counter would switch passes too early, and the bench would see the address sequence diverge.

Probe and write accesses test the flag update and the write-back. A probe that writes, or a changed flag set on reads, shows up in the access trace and in the stored word. The bench also holds new request values while a walk is running, and moves the table base into the second region so the region select is exercised.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;
  typedef enum logic [1:0] {
    ACC_PROBE = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_FETCH = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_WT0, ST_RD1, ST_WT1, ST_WR, ST_WTW, ST_FIN
  } walk_st_e;

  // second-word flag positions
  localparam int W1_REF = 8;
  localparam int W1_CHG = 7;
  localparam int PG_SHIFT = 12;
  localparam int GRP_SHIFT = 6;
endpackage

// File: rtl/pgw_hash.sv
`timescale 1ns/1ps
module pgw_hash #(
  parameter int SID_W  = 24,
  parameter int PIX_W  = 16,
  parameter int HASH_W = 19,
  parameter int AW     = 32
) (
  input  logic [SID_W-1:0]  sid,
  input  logic [PIX_W-1:0]  pix,
  input  logic              second,
  input  logic [AW-1:0]     base,
  input  logic [HASH_W-1:0] mask,
  output logic [AW-1:0]     grp
);
  localparam int PAD_W = AW - HASH_W - pgw_pkg::GRP_SHIFT;

  logic [HASH_W-1:0] h_pri;
  logic [HASH_W-1:0] h_sel;

  always_comb begin
    h_pri = sid[HASH_W-1:0] ^ {{(HASH_W-PIX_W){1'b0}}, pix};
    h_sel = second ? ~h_pri : h_pri;
    grp   = {{PAD_W{1'b0}}, (h_sel & mask), {pgw_pkg::GRP_SHIFT{1'b0}}} | base;
  end
endmodule

// File: rtl/pgw_match.sv
`timescale 1ns/1ps
module pgw_match #(
  parameter int SID_W = 24,
  parameter int API_W = 6,
  parameter int DW    = 32
) (
  input  logic [DW-1:0]    word0,
  input  logic [SID_W-1:0] sid,
  input  logic [API_W-1:0] api,
  input  logic             second,
  output logic             hit
);
  localparam int HSEL_B = API_W;
  localparam int SID_LO = API_W + 1;
  localparam int VLD_B  = API_W + SID_W + 1;

  logic vld;
  logic hsel;
  logic sid_eq;
  logic api_eq;

  always_comb begin
    vld    = word0[VLD_B];
    hsel   = word0[HSEL_B];
    sid_eq = (word0[SID_LO +: SID_W] == sid);
    api_eq = (word0[API_W-1:0] == api);
    hit    = vld && sid_eq && api_eq && (hsel == second);
  end
endmodule

// File: rtl/pgw_update.sv
`timescale 1ns/1ps
module pgw_update
  import pgw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word1,
  input  acc_e          kind,
  output logic [DW-1:0] word1_upd
);
  always_comb begin
    word1_upd = word1;
    if (kind != ACC_PROBE) word1_upd[W1_REF] = 1'b1;
    if (kind == ACC_WRITE) word1_upd[W1_CHG] = 1'b1;
  end
endmodule

// File: rtl/pgw_walker.sv
`timescale 1ns/1ps
module pgw_walker
  import pgw_pkg::*;
#(
  parameter int SID_W  = 24,
  parameter int PIX_W  = 16,
  parameter int API_W  = 6,
  parameter int HASH_W = 19,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int GRP_N  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [SID_W-1:0]       req_sid,
  input  logic [PIX_W-1:0]       req_pix,
  input  logic [API_W-1:0]       req_api,
  input  logic [PG_SHIFT-1:0]    req_offset,
  input  logic [1:0]             req_kind,
  input  logic [AW-1:0]          cfg_base,
  input  logic [HASH_W-1:0]      cfg_hmask,
  output logic                   busy,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_wdata,
  output logic                   mem_alt,
  input  logic                   mem_rvalid,
  input  logic [DW-1:0]          mem_rdata,
  output logic                   done,
  output logic                   fault,
  output logic [AW-1:0]          paddr,
  output logic                   fill_valid,
  output logic [SID_W+PIX_W-1:0] fill_tag,
  output logic [DW-1:0]          fill_pte
);
  localparam int IDX_W = $clog2(GRP_N);
  localparam int RPN_W = AW - PG_SHIFT;
  localparam int STEP_SH = 3;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(GRP_N - 1);

  walk_st_e            st_q, st_d;
  logic [SID_W-1:0]    sid_q;
  logic [PIX_W-1:0]    pix_q;
  logic [API_W-1:0]    api_q;
  logic [PG_SHIFT-1:0] off_q;
  acc_e                kind_q;
  logic                pass_q, pass_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [AW-1:0]       grp_q;
  logic [DW-1:0]       w1_q;
  logic                fault_q, fault_d;

  logic cap_en, grp_en, idx_en, pass_en, w1_en, fault_en;

  logic [SID_W-1:0] h_sid;
  logic [PIX_W-1:0] h_pix;
  logic             h_second;
  logic [AW-1:0]    grp_new;
  logic             ent_hit;
  logic [DW-1:0]    w1_upd;
  logic [AW-1:0]    ent_addr;

  // one hash unit shared between request capture and the pass switch
  assign h_sid    = (st_q == ST_IDLE) ? req_sid : sid_q;
  assign h_pix    = (st_q == ST_IDLE) ? req_pix : pix_q;
  assign h_second = (st_q != ST_IDLE);

  pgw_hash #(.SID_W(SID_W), .PIX_W(PIX_W), .HASH_W(HASH_W), .AW(AW)) u_hash (
    .sid(h_sid), .pix(h_pix), .second(h_second),
    .base(cfg_base), .mask(cfg_hmask), .grp(grp_new)
  );

  pgw_match #(.SID_W(SID_W), .API_W(API_W), .DW(DW)) u_match (
    .word0(mem_rdata), .sid(sid_q), .api(api_q), .second(pass_q), .hit(ent_hit)
  );

  pgw_update #(.DW(DW)) u_upd (
    .word1(mem_rdata), .kind(kind_q), .word1_upd(w1_upd)
  );

  assign ent_addr = grp_q + {{(AW-IDX_W-STEP_SH){1'b0}}, idx_q, {STEP_SH{1'b0}}};

  // next-state logic
  always_comb begin
    st_d     = st_q;
    pass_d   = pass_q;
    idx_d    = idx_q;
    fault_d  = fault_q;
    cap_en   = 1'b0;
    grp_en   = 1'b0;
    idx_en   = 1'b0;
    pass_en  = 1'b0;
    w1_en    = 1'b0;
    fault_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en   = 1'b1;
          grp_en   = 1'b1;
          idx_en   = 1'b1;
          pass_en  = 1'b1;
          fault_en = 1'b1;
          idx_d    = '0;
          pass_d   = 1'b0;
          fault_d  = 1'b0;
          st_d     = ST_RD0;
        end
      end
      ST_RD0: st_d = ST_WT0;
      ST_WT0: begin
        if (mem_rvalid) begin
          if (ent_hit) begin
            st_d = ST_RD1;
          end else if (idx_q != IDX_LAST) begin
            idx_en = 1'b1;
            idx_d  = idx_q + 1'b1;
            st_d   = ST_RD0;
          end else if (!pass_q) begin
            idx_en  = 1'b1;
            pass_en = 1'b1;
            grp_en  = 1'b1;
            idx_d   = '0;
            pass_d  = 1'b1;
            st_d    = ST_RD0;
          end else begin
            fault_en = 1'b1;
            fault_d  = 1'b1;
            st_d     = ST_FIN;
          end
        end
      end
      ST_RD1: st_d = ST_WT1;
      ST_WT1: begin
        if (mem_rvalid) begin
          w1_en = 1'b1;
          st_d  = (kind_q == ACC_PROBE) ? ST_FIN : ST_WR;
        end
      end
      ST_WR:  st_d = ST_WTW;
      ST_WTW: if (mem_rvalid) st_d = ST_FIN;
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sid_q   <= '0;
      pix_q   <= '0;
      api_q   <= '0;
      off_q   <= '0;
      kind_q  <= ACC_PROBE;
      pass_q  <= 1'b0;
      idx_q   <= '0;
      grp_q   <= '0;
      w1_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cap_en) begin
        sid_q  <= req_sid;
        pix_q  <= req_pix;
        api_q  <= req_api;
        off_q  <= req_offset;
        kind_q <= acc_e'(req_kind);
      end
      if (grp_en)   grp_q   <= grp_new;
      if (idx_en)   idx_q   <= idx_d;
      if (pass_en)  pass_q  <= pass_d;
      if (w1_en)    w1_q    <= w1_upd;
      if (fault_en) fault_q <= fault_d;
    end
  end

  // outputs
  always_comb begin
    busy       = (st_q != ST_IDLE);
    mem_req    = (st_q == ST_RD0) || (st_q == ST_RD1) || (st_q == ST_WR);
    mem_we     = (st_q == ST_WR);
    mem_addr   = (st_q == ST_RD0) ? ent_addr : (ent_addr | AW'(4));
    mem_wdata  = w1_q;
    mem_alt    = (grp_q[AW-1 -: 4] == 4'h1);
    done       = (st_q == ST_FIN);
    fault      = done && fault_q;
    paddr      = (done && !fault_q) ? {w1_q[DW-1 -: RPN_W], off_q} : '0;
    fill_valid = done && !fault_q && (kind_q != ACC_PROBE);
    fill_tag   = {sid_q, pix_q};
    fill_pte   = w1_q;
  end
endmodule

// File: rtl/pgw_checks.sv
`timescale 1ns/1ps
module pgw_checks
  import pgw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          req_kind,
  input logic [PG_SHIFT-1:0] req_offset,
  input logic                busy,
  input logic                mem_req,
  input logic                mem_we,
  input logic [AW-1:0]       mem_addr,
  input logic [DW-1:0]       mem_wdata,
  input logic                mem_alt,
  input logic                done,
  input logic                fault,
  input logic [AW-1:0]       paddr,
  input logic                fill_valid
);
  logic [PG_SHIFT-1:0] cap_off;
  logic [1:0]          cap_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_off  <= '0;
      cap_kind <= '0;
    end else if (req_valid && !busy) begin
      cap_off  <= req_offset;
      cap_kind <= req_kind;
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req) else $error("req held");                          // R12
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy) else $error("req while idle");                         // R1
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)) else $error("unaligned");          // R3
  AST_WB_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr[2:0] == 3'b100)) else $error("wb addr"); // R7
  AST_PROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cap_kind == 2'd0) |-> !(mem_req && mem_we)) else $error("probe wr"); // R7
  AST_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && cap_kind == 2'd2) |-> (mem_wdata[W1_REF] && mem_wdata[W1_CHG]))
    else $error("write flags");                                             // R6
  AST_ALT_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_alt == (mem_addr[AW-1 -: 4] == 4'h1))) else $error("alt"); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done held");                               // R8
  AST_PADDR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (paddr[PG_SHIFT-1:0] == cap_off)) else $error("offset"); // R8
  AST_FILL_ONLY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (done && !fault && cap_kind != 2'd0)) else $error("fill"); // R10
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done) else $error("fault");                                   // R9
endmodule

bind pgw_walker pgw_checks #(.AW(AW), .DW(DW)) u_pgw_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_offset(req_offset), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_alt(mem_alt), .done(done),
  .fault(fault), .paddr(paddr), .fill_valid(fill_valid)
);

// File: tb/test_pgw_walker.sv
`timescale 1ns/1ps
module test_pgw_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [23:0] req_sid;
  logic [15:0] req_pix;
  logic [5:0]  req_api;
  logic [11:0] req_offset;
  logic [1:0]  req_kind;
  logic [31:0] cfg_base;
  logic [18:0] cfg_hmask;
  logic        busy, mem_req, mem_we, mem_alt, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, fault, fill_valid;
  logic [31:0] paddr, fill_pte;
  logic [39:0] fill_tag;

  always #2.5 clk = ~clk;

  pgw_walker i_pgw_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sid(req_sid),
    .req_pix(req_pix), .req_api(req_api), .req_offset(req_offset),
    .req_kind(req_kind), .cfg_base(cfg_base), .cfg_hmask(cfg_hmask),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_alt(mem_alt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .fault(fault), .paddr(paddr),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_pte(fill_pte)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [31:0] mem [int unsigned];
  typedef struct packed { logic we; logic [31:0] addr; logic [31:0] data; } acc_t;
  acc_t expq[$];
  int   cnt = 0;
  int   lat = 1;
  logic [31:0] resp;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (rst_n) begin
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = resp;
        end
      end
      if (mem_req) begin
        acc_t e;
        chk(cnt == 0, "R12 request while outstanding", 64'(cnt), 64'd0);
        chk(mem_alt == (mem_addr[31:28] == 4'h1), "R11 region select", 64'(mem_alt), 64'(mem_addr[31:28] == 4'h1));
        chk(expq.size() > 0, "R2/R3 unexpected access", 64'(mem_addr), 64'd0);
        if (expq.size() > 0) begin
          e = expq.pop_front();
          chk(mem_we == e.we && mem_addr == e.addr, "R2/R3/R5 access order",
              {31'd0, mem_we, mem_addr}, {31'd0, e.we, e.addr});
          if (e.we) chk(mem_wdata == e.data, "R6/R7 write-back data", 64'(mem_wdata), 64'(e.data));
        end
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          resp = 32'h0;
        end else begin
          resp = rd(mem_addr);
        end
        lat = (lat % 3) + 1;
        cnt = lat;
      end
    end
  end

  // ---------------- reference model ----------------
  logic        exp_fault;
  logic [31:0] exp_w1;

  function automatic logic [31:0] grp(input logic [23:0] sid, input logic [15:0] pix, input bit pass);
    logic [18:0] h;
    h = sid[18:0] ^ {3'b000, pix};
    if (pass) h = ~h;
    return {7'd0, h & cfg_hmask, 6'd0} | cfg_base;
  endfunction

  function automatic logic [31:0] mk0(input bit v, input logic [23:0] sid, input bit h, input logic [5:0] api);
    return {v, sid, h, api};
  endfunction

  task automatic put(input logic [23:0] sid, input logic [15:0] pix, input bit pass, input int slot,
                     input logic [31:0] w0, input logic [31:0] w1);
    logic [31:0] a;
    a = grp(sid, pix, pass) + 32'(8 * slot);
    mem[a]     = w0;
    mem[a + 4] = w1;
  endtask

  task automatic model(input logic [23:0] sid, input logic [15:0] pix, input logic [5:0] api, input logic [1:0] kind);
    exp_fault = 1'b1;
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 8; i++) begin
        logic [31:0] a, w0, w1;
        a  = grp(sid, pix, p[0]) + 32'(8 * i);
        expq.push_back('{1'b0, a, 32'h0});
        w0 = rd(a);
        if (w0[31] && w0[30:7] == sid && w0[5:0] == api && w0[6] == p[0]) begin
          expq.push_back('{1'b0, a + 4, 32'h0});
          w1 = rd(a + 4);
          if (kind != 2'd0) w1[8] = 1'b1;
          if (kind == 2'd2) w1[7] = 1'b1;
          if (kind != 2'd0) expq.push_back('{1'b1, a + 4, w1});
          exp_w1    = w1;
          exp_fault = 1'b0;
          return;
        end
      end
    end
  endtask

  task automatic walk(input logic [23:0] sid, input logic [15:0] pix, input logic [5:0] api,
                      input logic [11:0] off, input logic [1:0] kind, input bit noisy);
    int n;
    model(sid, pix, api, kind);
    @(negedge clk);
    req_sid = sid; req_pix = pix; req_api = api; req_offset = off; req_kind = kind;
    req_valid = 1'b1;
    @(negedge clk);
    if (noisy) begin
      // R1: new values held on the request port while busy must be ignored
      req_sid = ~sid; req_pix = ~pix; req_api = ~api; req_offset = ~off; req_kind = 2'd2;
      chk(busy == 1'b1, "R1 busy after accept", 64'(busy), 64'd1);
      repeat (3) @(negedge clk);
    end
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R8 done seen", 64'(done), 64'd1);
    if (done) begin
      chk(fault == exp_fault, "R9 fault flag", 64'(fault), 64'(exp_fault));
      if (!exp_fault)
        chk(paddr == {exp_w1[31:12], off}, "R8 physical address", 64'(paddr), 64'({exp_w1[31:12], off}));
      chk(fill_valid == (!exp_fault && kind != 2'd0), "R10 fill strobe", 64'(fill_valid), 64'(!exp_fault && kind != 2'd0));
      if (!exp_fault && kind != 2'd0) begin
        chk(fill_pte == exp_w1, "R10 fill entry", 64'(fill_pte), 64'(exp_w1));
        chk(fill_tag == {sid, pix}, "R10 fill tag", 64'(fill_tag), 64'({sid, pix}));
      end
      chk(expq.size() == 0, "R3/R9 access count", 64'(expq.size()), 64'd0);
      @(negedge clk);
      chk(!done && !busy, "R8 done is a pulse", {62'd0, done, busy}, 64'd0);
    end
    expq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a;
    rst_n = 1'b0; req_valid = 1'b0; req_sid = '0; req_pix = '0; req_api = '0;
    req_offset = '0; req_kind = '0; mem_rvalid = 1'b0; mem_rdata = '0;
    cfg_base = 32'h0004_0000; cfg_hmask = 19'h000FF;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !fill_valid, "R1/R12 reset idle",
        {60'd0, busy, done, mem_req, fill_valid}, 64'd0);
    rst_n = 1'b1;

    // R2/R6: primary hit in slot 0, read sets only the referenced flag
    put(24'h012345, 16'h0010, 0, 0, mk0(1, 24'h012345, 0, 6'd5), 32'hABCDE000);
    walk(24'h012345, 16'h0010, 6'd5, 12'h3A7, 2'd1, 0);
    a = grp(24'h012345, 16'h0010, 0) + 4;
    chk(rd(a) == 32'hABCDE100, "R6 read sets referenced only", 64'(rd(a)), 64'hABCDE100);

    // R4: decoys in slots 0-6, real write hit in last slot
    put(24'h00ABCD, 16'h0001, 0, 0, mk0(0, 24'h00ABCD, 0, 6'd9), 32'h11111000);
    put(24'h00ABCD, 16'h0001, 0, 1, mk0(1, 24'h00ABCD, 0, 6'd8), 32'h22222000);
    put(24'h00ABCD, 16'h0001, 0, 2, mk0(1, 24'h00ABCD, 1, 6'd9), 32'h33333000);
    put(24'h00ABCD, 16'h0001, 0, 3, mk0(1, 24'h00ABCC, 0, 6'd9), 32'h44444000);
    put(24'h00ABCD, 16'h0001, 0, 7, mk0(1, 24'h00ABCD, 0, 6'd9), 32'h55555000);
    walk(24'h00ABCD, 16'h0001, 6'd9, 12'hFFF, 2'd2, 0);
    a = grp(24'h00ABCD, 16'h0001, 0) + 56 + 4;
    chk(rd(a) == 32'h55555180, "R6/R7 write sets both flags", 64'(rd(a)), 64'h55555180);

    // R5: primary holds only a wrong-pass match; secondary hit after a wrong-pass decoy
    put(24'h0F0F0F, 16'h0000, 0, 2, mk0(1, 24'h0F0F0F, 1, 6'd3), 32'h66666000);
    put(24'h0F0F0F, 16'h0000, 1, 1, mk0(1, 24'h0F0F0F, 0, 6'd3), 32'h77777000);
    put(24'h0F0F0F, 16'h0000, 1, 3, mk0(1, 24'h0F0F0F, 1, 6'd3), 32'h88888000);
    walk(24'h0F0F0F, 16'h0000, 6'd3, 12'h010, 2'd3, 0);
    a = grp(24'h0F0F0F, 16'h0000, 1) + 24 + 4;
    chk(rd(a) == 32'h88888100, "R5/R6 fetch in secondary group", 64'(rd(a)), 64'h88888100);

    // R7: probe hit leaves memory untouched and offers no fill
    put(24'h000077, 16'h0044, 0, 4, mk0(1, 24'h000077, 0, 6'd1), 32'h9ABCD000);
    walk(24'h000077, 16'h0044, 6'd1, 12'h123, 2'd0, 0);
    a = grp(24'h000077, 16'h0044, 0) + 32 + 4;
    chk(rd(a) == 32'h9ABCD000, "R7 probe writes nothing", 64'(rd(a)), 64'h9ABCD000);

    // R9: full miss
    walk(24'h111111, 16'h2222, 6'd7, 12'h000, 2'd1, 0);

    // R1: request lines toggled while busy
    walk(24'h012345, 16'h0010, 6'd5, 12'h444, 2'd1, 1);

    // R6: second write to an entry whose flags are already set
    walk(24'h00ABCD, 16'h0001, 6'd9, 12'h001, 2'd2, 0);

    // R11: table placed in the second region
    cfg_base = 32'h1000_0000;
    put(24'h000123, 16'h0456, 0, 1, mk0(1, 24'h000123, 0, 6'd2), 32'hC0DE0000);
    walk(24'h000123, 16'h0456, 6'd2, 12'h0F0, 2'd2, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule